// File: doc/BRIEF.md
# I2C Target Controller with Selectable Clock Stretching

This block is the target (slave) side of an I2C bus. It runs on a system clock that oversamples the SCL and SDA lines, and it drives both lines open-drain. It finds START and STOP conditions and compares the address byte with a 7-bit own address. It can also answer the all-zero general call address. The block records the R/W bit, receives data bytes and sends data bytes. In a write transfer it returns the acknowledge value that software has chosen.

Software controls the block through a 16-bit control register. This register enables the target, turns on clock stretching and selects where the stretch happens: after the 8th or the 9th SCL falling edge of a byte. While a stretch is active, software can read the received byte or prepare the next byte to send. A release strobe ends the stretch. In a read transfer, loading the transmit byte also ends it. A strobe marks each completed data byte.

Top module: `i2c_target`

## Requirements
- R1: After reset the control register reads 0x0001 (target enabled, every other bit 0), and SCL and SDA are both released.
- R2: The control register reads back as {6'b0, stretch_en[9], gcall_en[8], 2'b0, nack_sel[5], stretch_at8[4], 1'b0, dir[2], host_sel[1], enable[0]}. The reserved bits always read 0, so a write of 0xFFFF while idle reads back as 0x0333.
- R3: A write to the enable bit (bit 0) has no effect while the bus is busy. The other writable bits take the written value at any time.
- R4: A START (SDA falls while SCL is high) marks the bus busy and begins address reception. A STOP (SDA rises while SCL is high) marks the bus idle and releases both lines.
- R5: When the first 7 bits of the address byte equal own_addr, the target pulls SDA low in the 9th clock. Otherwise it leaves SDA released for the rest of the transfer and raises no byte_done.
- R6: The address byte 0x00 gets an acknowledge only when gcall_en is 1.
- R7: In a write transfer each data byte appears on rx_data with a one-cycle byte_done pulse. The acknowledge clock leaves SDA released when nack_sel is 1 and pulls it low when nack_sel is 0. nack_sel keeps its value until software rewrites it.
- R8: The direction bit (bit 2) takes the R/W bit of each matched address byte. Software writes to it have no effect.
- R9: With stretch_en = 1 and stretch_at8 = 1, the target holds SCL low after the 8th SCL falling edge of each byte it handles.
- R10: With stretch_en = 1 and stretch_at8 = 0, SCL is held low after the 9th falling edge. With stretch_en = 0 the target never holds SCL, whatever stretch_at8 is set to.
- R11: An active stretch ends when stretch_rel is pulsed. In a read transfer it also ends when tx_load is pulsed, and a stretch after the 9th edge then sends the newly loaded byte.
- R12: In a read transfer the target sends the byte held from tx_load, MSB first. After a master NACK it keeps SDA released until the next START.
- R13: While enable is 0 the target never drives SCL or SDA.
- R14: The host-select bit (bit 1) is stored and read back but does not change target behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Own 7-bit target address |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 16 | Control register write data |
| reg_rdata | output | 16 | Control register read data |
| tx_load | input | 1 | Loads tx_data as the next byte to send |
| tx_data | input | 8 | Byte to send in read transfers |
| stretch_rel | input | 1 | Ends an active stretch |
| rx_data | output | 8 | Last byte received in a write transfer |
| byte_done | output | 1 | One-cycle pulse per completed data byte |

## Verification
The assertions assume that the sensed bus lines obey I2C rules. SDA changes while SCL is high only to form a START or a STOP. Each SCL level lasts well beyond the synchronizer delay, so no edge is lost or merged. They also assume that stretch_rel arrives only while SCL is held low and never in the same cycle as a new stretch. The bench master keeps within these assumptions. It drives a quarter-bit of ten system clocks and changes SDA only after it has pulled SCL low. It waits for a released SCL to read high before it counts a clock, and it pulses the release strobes only after it has seen the target holding SCL.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int CR_W    = 16;
  localparam int BYTE_W  = 8;
  localparam int TADDR_W = 7;

  localparam int CB_EN   = 0;
  localparam int CB_HOST = 1;
  localparam int CB_DIR  = 2;
  localparam int CB_AT8  = 4;
  localparam int CB_NACK = 5;
  localparam int CB_GC   = 8;
  localparam int CB_STR  = 9;

  typedef enum logic [2:0] {
    TS_IDLE, TS_ADDR, TS_RX, TS_TX, TS_WAIT
  } tstate_e;

  typedef struct packed {
    logic str_en;
    logic gc_en;
    logic nack_sel;
    logic at8;
    logic host;
    logic en;
  } tcfg_t;

  // address byte match: own address, or general call when allowed
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [TADDR_W-1:0] own,
                                    input logic gc);
    return (b[BYTE_W-1:1] == own) || (gc && (b == '0));
  endfunction

  function automatic logic [CR_W-1:0] cfg_pack(input tcfg_t c, input logic dir);
    logic [CR_W-1:0] r;
    r = '0;
    r[CB_EN]   = c.en;
    r[CB_HOST] = c.host;
    r[CB_DIR]  = dir;
    r[CB_AT8]  = c.at8;
    r[CB_NACK] = c.nack_sel;
    r[CB_GC]   = c.gc_en;
    r[CB_STR]  = c.str_en;
    return r;
  endfunction

  // stretch decision at the 8th (at8_edge=1) or 9th (0) falling edge
  function automatic logic stretch_now(input logic str_en, input logic at8,
                                       input logic at8_edge);
    return str_en && (at8 == at8_edge);
  endfunction
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2ct_ctrl.sv
module i2ct_ctrl
  import i2ct_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [CR_W-1:0] wdata,
  input  logic            busy,
  input  logic            dir,
  output tcfg_t           cfg,
  output logic [CR_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '{str_en: 1'b0, gc_en: 1'b0, nack_sel: 1'b0, at8: 1'b0,
               host: 1'b0, en: 1'b1};
    end else if (wr) begin
      cfg.str_en   <= wdata[CB_STR];
      cfg.gc_en    <= wdata[CB_GC];
      cfg.nack_sel <= wdata[CB_NACK];
      cfg.at8      <= wdata[CB_AT8];
      cfg.host     <= wdata[CB_HOST];
      if (!busy) cfg.en <= wdata[CB_EN];
    end
  end

  assign rdata = cfg_pack(cfg, dir);
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_s,
  input  logic               sda_s,
  input  logic               en,
  input  logic               gc_en,
  input  logic               nack_sel,
  input  logic               str_en,
  input  logic               at8,
  input  logic [TADDR_W-1:0] own_addr,
  input  logic               tx_load,
  input  logic [BYTE_W-1:0]  tx_data,
  input  logic               stretch_rel,
  output logic               scl_oe,
  output logic               sda_oe,
  output logic [BYTE_W-1:0]  rx_data,
  output logic               byte_done,
  output logic               busy,
  output logic               dir,
  output logic               start_evt,
  output logic               stop_evt,
  output logic               addr_done
);
  localparam logic [3:0] LAST_DATA = 4'(BYTE_W);
  localparam logic [3:0] ACK_CLK   = 4'(BYTE_W + 1);

  logic scl_p, sda_p;
  logic scl_rise, scl_fall;
  tstate_e state;
  logic [3:0] bitn;
  logic [BYTE_W-1:0] shreg, txsh, tx_hold;
  logic mnack;
  logic in_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
  assign in_byte   = (state == TS_ADDR) || (state == TS_RX) || (state == TS_TX);
  assign addr_done = (state == TS_ADDR) && scl_fall && (bitn == LAST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= TS_IDLE;
      bitn      <= '0;
      shreg     <= '0;
      txsh      <= '0;
      tx_hold   <= '0;
      mnack     <= 1'b0;
      busy      <= 1'b0;
      dir       <= 1'b0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      rx_data   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (tx_load) tx_hold <= tx_data;
      if (start_evt) begin
        busy   <= 1'b1;
        state  <= en ? TS_ADDR : TS_IDLE;
        bitn   <= '0;
        mnack  <= 1'b0;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else if (stop_evt) begin
        busy   <= 1'b0;
        state  <= TS_IDLE;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else begin
        if (scl_oe && (stretch_rel || (tx_load && dir))) begin
          scl_oe <= 1'b0;
          if (tx_load && dir && state == TS_TX && bitn == '0) begin
            txsh   <= tx_data;
            sda_oe <= ~tx_data[BYTE_W-1];
          end
        end
        if (in_byte && scl_rise) begin
          if (bitn < LAST_DATA) shreg <= {shreg[BYTE_W-2:0], sda_s};
          else if (state == TS_TX && sda_s) mnack <= 1'b1;
          bitn <= bitn + 4'd1;
        end
        if (in_byte && scl_fall) begin
          if (bitn == LAST_DATA) begin
            case (state)
              TS_ADDR: begin
                if (addr_hit(shreg, own_addr, gc_en)) begin
                  sda_oe <= 1'b1;
                  dir    <= shreg[0];
                  scl_oe <= stretch_now(str_en, at8, 1'b1);
                end else begin
                  state <= TS_WAIT;
                end
              end
              TS_RX: begin
                rx_data   <= shreg;
                byte_done <= 1'b1;
                sda_oe    <= ~nack_sel;
                scl_oe    <= stretch_now(str_en, at8, 1'b1);
              end
              default: begin
                byte_done <= 1'b1;
                sda_oe    <= 1'b0;
                scl_oe    <= stretch_now(str_en, at8, 1'b1);
              end
            endcase
          end else if (bitn == ACK_CLK) begin
            bitn   <= '0;
            sda_oe <= 1'b0;
            if (state == TS_TX && mnack) begin
              state <= TS_WAIT;
            end else begin
              scl_oe <= stretch_now(str_en, at8, 1'b0);
              if ((state == TS_ADDR && dir) || state == TS_TX) begin
                state  <= TS_TX;
                txsh   <= tx_hold;
                sda_oe <= ~tx_hold[BYTE_W-1];
              end else begin
                state <= TS_RX;
              end
            end
          end else if (state == TS_TX && bitn != '0) begin
            txsh   <= {txsh[BYTE_W-2:0], 1'b0};
            sda_oe <= ~txsh[BYTE_W-2];
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_target.sv
module i2c_target
  import i2ct_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic [6:0]  own_addr,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        tx_load,
  input  logic [7:0]  tx_data,
  input  logic        stretch_rel,
  output logic [7:0]  rx_data,
  output logic        byte_done
);
  localparam int LINES = 2;

  logic [LINES-1:0] line_s;
  tcfg_t cfg;
  logic busy, dir, start_evt, stop_evt, addr_done;
  logic cfg_en, cfg_str;

  i2ct_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(line_s)
  );

  i2ct_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
    .busy(busy), .dir(dir), .cfg(cfg), .rdata(reg_rdata)
  );

  i2ct_engine u_eng (
    .clk(clk), .rst_n(rst_n), .scl_s(line_s[1]), .sda_s(line_s[0]),
    .en(cfg.en), .gc_en(cfg.gc_en), .nack_sel(cfg.nack_sel),
    .str_en(cfg.str_en), .at8(cfg.at8), .own_addr(own_addr),
    .tx_load(tx_load), .tx_data(tx_data), .stretch_rel(stretch_rel),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_data(rx_data),
    .byte_done(byte_done), .busy(busy), .dir(dir),
    .start_evt(start_evt), .stop_evt(stop_evt), .addr_done(addr_done)
  );

  assign cfg_en  = cfg.en;
  assign cfg_str = cfg.str_en;
endmodule

// File: rtl/i2c_target_chk.sv
module i2c_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        start_evt,
  input logic        stop_evt,
  input logic        addr_done,
  input logic        dir,
  input logic        cfg_en,
  input logic        cfg_str,
  input logic        reg_wr,
  input logic        stretch_rel,
  input logic        scl_oe,
  input logic        sda_oe,
  input logic [15:0] reg_rdata
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[15:10] == '0) && (reg_rdata[7:6] == '0) && !reg_rdata[3]);

  a_r3_enable_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr) |=> (cfg_en == $past(cfg_en)));

  a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

  a_r4_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!busy && !scl_oe && !sda_oe));

  a_r8_dir_hw_only: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_done |=> $stable(dir));

  a_r10_stretch_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> $past(cfg_str));

  a_r11_strobe_release: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && stretch_rel) |=> !scl_oe);

  a_r13_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_target i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start_evt(start_evt),
  .stop_evt(stop_evt), .addr_done(addr_done), .dir(dir), .cfg_en(cfg_en),
  .cfg_str(cfg_str), .reg_wr(reg_wr), .stretch_rel(stretch_rel),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_rdata(reg_rdata)
);

// File: tb/tb_i2c_target.sv
module tb_i2c_target;
  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h5A;
  localparam logic [7:0] AW = {OWN, 1'b0};
  localparam logic [7:0] AR = {OWN, 1'b1};

  logic clk = 0, rst_n = 0;
  logic m_scl_low = 0, m_sda_low = 0;
  logic reg_wr = 0, tx_load = 0, stretch_rel = 0;
  logic [15:0] reg_wdata = 0;
  logic [7:0] tx_data = 0;
  logic scl_oe, sda_oe, byte_done;
  logic [15:0] reg_rdata;
  logic [7:0] rx_data;
  wire scl_line = !(m_scl_low || scl_oe);
  wire sda_line = !(m_sda_low || sda_oe);

  int n_chk = 0, n_err = 0, done_cnt = 0;
  logic [7:0] got_rx = 0;
  logic rel_tx = 0, any_drive = 0;
  logic [7:0] tx_next = 0;

  always #4 clk = ~clk;

  i2c_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_load(tx_load),
    .tx_data(tx_data), .stretch_rel(stretch_rel), .rx_data(rx_data),
    .byte_done(byte_done)
  );

  always @(posedge clk) begin
    if (byte_done) begin
      got_rx <= rx_data;
      done_cnt <= done_cnt + 1;
    end
    if (scl_oe || sda_oe) any_drive <= 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [15:0] v);
    @(negedge clk); reg_wr = 1; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic load_tx(input logic [7:0] v);
    @(negedge clk); tx_load = 1; tx_data = v;
    @(negedge clk); tx_load = 0;
  endtask

  // one SCL clock; returns SDA sampled in the high phase and whether the
  // target held SCL after the falling edge (then releases it)
  task automatic clk_pulse(output logic smp, output logic st);
    wait_n(Q);
    m_scl_low = 0;
    while (!scl_line) @(negedge clk);
    wait_n(Q); smp = sda_line; wait_n(Q);
    m_scl_low = 1;
    wait_n(Q);
    st = scl_oe;
    if (st) begin
      wait_n(4);
      if (rel_tx) begin tx_data = tx_next; tx_load = 1; end
      else stretch_rel = 1;
      @(negedge clk); tx_load = 0; stretch_rel = 0;
      wait_n(2);
    end
  endtask

  task automatic m_start();
    m_sda_low = 0; m_scl_low = 0; wait_n(2*Q);
    m_sda_low = 1; wait_n(2*Q);
    m_scl_low = 1; wait_n(Q);
  endtask

  task automatic m_stop();
    m_sda_low = 1; wait_n(Q);
    m_scl_low = 0; wait_n(2*Q);
    m_sda_low = 0; wait_n(2*Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack, output logic st8,
                         output logic st9);
    logic s, t;
    st8 = 0;
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = !b[i];
      clk_pulse(s, t);
      if (i == 0) st8 = t;
    end
    m_sda_low = 0;
    clk_pulse(ack, st9);
  endtask

  task automatic rd_byte(input logic nack, output logic [7:0] b, output logic st9);
    logic s, t;
    m_sda_low = 0;
    for (int i = 7; i >= 0; i--) begin
      clk_pulse(s, t);
      b[i] = s;
    end
    m_sda_low = !nack;
    clk_pulse(s, st9);
    m_sda_low = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset register", reg_rdata, 16'h0001);
    chk("R1 lines released", {scl_oe, sda_oe}, 2'b00);
  endtask

  task automatic t_fields();
    reg_write(16'hFFFF);
    chk("R2/R8 all-ones write readback", reg_rdata, 16'h0333);
    reg_write(16'h0003);
    chk("R14 host bit stored", reg_rdata, 16'h0003);
  endtask

  task automatic t_write_xfer();
    logic a, s8, s9;
    int d0;
    m_start();
    wr_byte(AW, a, s8, s9);
    chk("R4/R5 own address acked (host bit set, R14)", a, 1'b0);
    reg_write(16'h0001);
    d0 = done_cnt;
    wr_byte(8'hC3, a, s8, s9);
    chk("R7 data acked", a, 1'b0);
    chk("R7 rx byte", got_rx, 8'hC3);
    reg_write(16'h0021);
    wr_byte(8'h3C, a, s8, s9);
    chk("R7 nack selected", a, 1'b1);
    chk("R7 rx byte after nack", got_rx, 8'h3C);
    chk("R7 byte_done count", done_cnt - d0, 2);
    chk("R7 nack select sticky", reg_rdata, 16'h0021);
    m_stop();
    reg_write(16'h0001);
  endtask

  task automatic t_wrong_addr();
    logic a, s8, s9;
    int d0;
    d0 = done_cnt;
    m_start();
    wr_byte(8'h22, a, s8, s9);
    chk("R5 foreign address not acked", a, 1'b1);
    wr_byte(8'h77, a, s8, s9);
    chk("R5 no byte_done after miss", done_cnt - d0, 0);
    m_stop();
  endtask

  task automatic t_gencall();
    logic a, s8, s9;
    m_start();
    wr_byte(8'h00, a, s8, s9);
    chk("R6 general call ignored when off", a, 1'b1);
    m_stop();
    reg_write(16'h0101);
    m_start();
    wr_byte(8'h00, a, s8, s9);
    chk("R6 general call acked when on", a, 1'b0);
    wr_byte(8'h42, a, s8, s9);
    chk("R6 general call data", got_rx, 8'h42);
    m_stop();
    reg_write(16'h0001);
  endtask

  task automatic t_enable_lock();
    logic a, s8, s9;
    m_start();
    wr_byte(AW, a, s8, s9);
    reg_write(16'h0000);
    chk("R3 enable locked while busy", reg_rdata, 16'h0001);
    m_stop();
    reg_write(16'h0000);
    chk("R3/R4 enable writable after STOP", reg_rdata, 16'h0000);
    @(negedge clk); any_drive = 0;
    m_start();
    wr_byte(AW, a, s8, s9);
    chk("R13 disabled target no ack", a, 1'b1);
    wr_byte(8'h55, a, s8, s9);
    m_stop();
    chk("R13 disabled target never drove", any_drive, 1'b0);
    reg_write(16'h0001);
  endtask

  task automatic t_read_xfer();
    logic a, s8, s9;
    logic [7:0] b;
    int d0;
    load_tx(8'hA5);
    d0 = done_cnt;
    m_start();
    wr_byte(AR, a, s8, s9);
    chk("R5 read address acked", a, 1'b0);
    chk("R8 direction bit set by read", reg_rdata, 16'h0005);
    reg_write(16'h0001);
    chk("R8 direction write ignored", reg_rdata, 16'h0005);
    load_tx(8'h5B);
    rd_byte(1'b0, b, s9);
    chk("R12 first byte MSB first", b, 8'hA5);
    rd_byte(1'b1, b, s9);
    chk("R12 second byte", b, 8'h5B);
    rd_byte(1'b1, b, s9);
    chk("R12 SDA released after master NACK", b, 8'hFF);
    chk("R12 byte_done per sent byte", done_cnt - d0, 2);
    m_stop();
  endtask

  task automatic t_stretch9();
    logic a, s8, s9;
    reg_write(16'h0201);
    m_start();
    wr_byte(AW, a, s8, s9);
    chk("R10 no stretch at 8th edge", s8, 1'b0);
    chk("R10 stretch at 9th edge", s9, 1'b1);
    wr_byte(8'h81, a, s8, s9);
    chk("R11 strobe release, transfer continues", got_rx, 8'h81);
    chk("R10 data byte stretch at 9th", {s8, s9}, 2'b01);
    m_stop();
  endtask

  task automatic t_stretch8();
    logic a, s8, s9;
    reg_write(16'h0211);
    m_start();
    wr_byte(AW, a, s8, s9);
    chk("R9 stretch at 8th edge", {s8, s9}, 2'b10);
    chk("R9 ack after stretch", a, 1'b0);
    wr_byte(8'h18, a, s8, s9);
    chk("R9 data byte stretch at 8th", {s8, s9}, 2'b10);
    chk("R9 rx byte", got_rx, 8'h18);
    m_stop();
  endtask

  task automatic t_stretch_off();
    logic a, s8, s9;
    reg_write(16'h0011);
    m_start();
    wr_byte(AW, a, s8, s9);
    chk("R10 stretch disabled ignores select", {s8, s9}, 2'b00);
    m_stop();
  endtask

  task automatic t_stretch_tx();
    logic a, s8, s9;
    logic [7:0] b;
    reg_write(16'h0201);
    load_tx(8'h00);
    rel_tx = 1; tx_next = 8'h96;
    m_start();
    wr_byte(AR, a, s8, s9);
    chk("R11 read stretch at 9th", s9, 1'b1);
    rd_byte(1'b1, b, s9);
    chk("R11 tx_load release sends new byte", b, 8'h96);
    m_stop();
    rel_tx = 0;
    reg_write(16'h0001);
  endtask

  initial begin
    wait_n(5);
    rst_n = 1;
    wait_n(5);
    t_reset();
    t_fields();
    t_write_xfer();
    t_wrong_addr();
    t_gencall();
    t_enable_lock();
    t_read_xfer();
    t_stretch9();
    t_stretch8();
    t_stretch_off();
    t_stretch_tx();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog R4 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule